// File: doc/BRIEF.md
# Clock-Calendar Register Front End

This block connects the time-of-day logic of a clock-calendar to an 8-bit processor bus. Three address lines pick one of eight slots: a control register, a freeze-arming slot, and five calendar counter bytes. Writes to the counter slots go either to the running counters or, if a control bit says so, to the three alarm latches. The block latches a chip select on the falling edge of an address strobe. It takes write data on the rising edge of an active-low write strobe, and it drives read data while an active-low read line is held low. All strobes are sampled on the system clock, so each bus phase must last at least one clock cycle.

The control byte sets the prescaler input rate, start/stop, the write target, and a 4-bit code. That code picks one of fifteen square-wave taps for the clock output, and code zero turns the output off. A completed access to slot 1 freezes the seconds tick so that a following access sees stable values. Ticks that arrive while frozen are stored and replayed afterwards. The freeze ends when an access to any other slot completes, or when a timeout window expires. A power-down input makes the block ignore the bus and pulls the clock output low. If an access is already under way, power-down waits until that access completes.

The bus is plain strobed handshaking with no back-pressure: every access that is presented is taken, and the control and status pins are plain levels.

Top module: `rtc_bus_frontend`

## Requirements
- R1: After reset the control byte is 0x00: `freq_sel` is 0, `run` is 0, `alm_target` is 0 and the clock output is deselected, so `clk_out` is high. `rdata_oe`, `cnt_wr_en` and `alm_wr_en` are 0.
- R2: `cs_in` is latched on each falling edge of `addr_strobe`. While the latched select is 0, reads do not drive `rdata_oe` and writes change nothing.
- R3: A write completes when `wr_n` rises while `rd_n` is high, using the `addr` and `wdata` present in that cycle. At address 0 the byte becomes the control register, with fields [1:0] `freq_sel`, [2] `run`, [3] `alm_target` (1 = alarm latches) and [7:4] clock-output select.
- R4: A completed write to address 2+i (i = 0..4: seconds, minutes, hours, day, month) pulses `cnt_wr_en` for one cycle with `wr_sel` = i when `alm_target` is 0. When `alm_target` is 1, the write pulses `alm_wr_en` with `wr_sel` = i for i = 0..2 and has no effect for i = 3..4. Writes to addresses 1 and 7 raise neither strobe. The strobes come one cycle after the completing edge and carry `wr_data` = the written byte.
- R5: While the latched select is 1 and `rd_n` is low, `rdata_oe` is 1 and `rdata` shows the following. Address 0 gives {`irq_alarm`, `irq_clk`, 6'b0}. Address 2+i gives byte i of `cnt_values` (bits 8i+7..8i). Addresses 1 and 7 give 0x00.
- R6: With select code 0, `clk_out` is 1. With code k in 1..15, `clk_out` follows `taps[k-1]`.
- R7: While `run` is 0, `sec_tick` pulses are not passed to `cnt_tick` and are not stored. While `run` is 1 and the block is not frozen, each `sec_tick` pulse gives one `cnt_tick` pulse.
- R8: A completed read or write at address 1 freezes the tick. While frozen, `cnt_tick` stays 0 and `sec_tick` pulses are counted, up to 2^PEND_W-1.
- R9: The freeze ends when an access to another address completes, or after WINDOW_CYCLES cycles without a new arming access. The stored ticks then come out on `cnt_tick`, one per cycle, so none is lost.
- R10: While power-down is in effect, bus writes and reads are ignored, `rdata_oe` is 0 and `clk_out` is 0.
- R11: Power-down (`pd_n` low) does not take effect while a selected read or write strobe is low. It takes effect on the edge where that access completes, and the access itself is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_strobe | input | 1 | Select latch strobe; falling edge latches `cs_in` |
| cs_in | input | 1 | Chip select level |
| addr | input | 3 | Slot address |
| rd_n | input | 1 | Active-low read |
| wr_n | input | 1 | Active-low write strobe, completes on rising edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not driven |
| rdata_oe | output | 1 | Read data valid/drive enable |
| pd_n | input | 1 | Active-low power-down request |
| cnt_values | input | 40 | Five counter bytes, seconds in bits 7:0 |
| irq_alarm | input | 1 | Alarm interrupt flag for status read |
| irq_clk | input | 1 | Clock-output interrupt flag for status read |
| taps | input | 15 | Square-wave taps from the prescaler |
| sec_tick | input | 1 | One-cycle seconds pulse |
| cnt_tick | output | 1 | Gated seconds pulse to the counters |
| cnt_wr_en | output | 1 | Counter write strobe |
| alm_wr_en | output | 1 | Alarm latch write strobe |
| wr_sel | output | 3 | Counter or latch index for the strobe |
| wr_data | output | 8 | Byte for the strobe |
| freq_sel | output | 2 | Prescaler input rate select |
| run | output | 1 | Start/stop |
| alm_target | output | 1 | Write target select |
| clk_out | output | 1 | Selected square wave |

## Verification
The assertions assume that bus strobes are synchronous to `clk` and that each strobe phase lasts at least one cycle. They also assume that `sec_tick` is a pulse of a single cycle with at least one idle cycle between pulses. The stimulus drives every input one time unit after a rising edge and holds each strobe level for at least one full cycle. Random control bytes, addresses, counter bytes and tap patterns stay inside the eight defined slots. Directed sequences cover freeze saturation, the timeout window, a deselected bus, and power-down that arrives during a write.

// File: rtl/rtc_bus_pkg.sv
package rtc_bus_pkg;
  localparam int ADDR_W    = 3;
  localparam int SEL_W     = 4;
  localparam int NUM_TAPS  = (1 << SEL_W) - 1;
  localparam int NUM_CNT   = 5;
  localparam int NUM_ALM   = 3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_FRZ  = 3'd1;
  localparam int ADDR_CNT0 = 2;

  typedef struct packed {
    logic [SEL_W-1:0] clk_sel;
    logic             alm_tgt;
    logic             run;
    logic [1:0]       freq;
  } ctrl_t;
endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_strobe,
  input  logic cs_in,
  input  logic rd_n,
  input  logic wr_n,
  input  logic pd_n,
  output logic cs_lat,
  output logic pd_active,
  output logic rd_live,
  output logic wr_evt,
  output logic rd_evt
);
  logic as_q, rd_q, wr_q, busy;

  assign busy    = cs_lat && (!rd_n || !wr_n);
  assign rd_live = cs_lat && !rd_n && !pd_active;
  assign wr_evt  = cs_lat && !pd_active && wr_n && !wr_q && rd_n;
  assign rd_evt  = cs_lat && !pd_active && rd_n && !rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_q      <= 1'b0;
      rd_q      <= 1'b1;
      wr_q      <= 1'b1;
      cs_lat    <= 1'b0;
      pd_active <= 1'b0;
    end else begin
      as_q      <= addr_strobe;
      rd_q      <= rd_n;
      wr_q      <= wr_n;
      pd_active <= !pd_n && (pd_active || !busy);
      if (as_q && !addr_strobe && !pd_active) cs_lat <= cs_in;
    end
  end

  p_pd_waits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pd_active) |=> !pd_active);
  p_evt_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_evt, rd_evt && !wr_n}));
endmodule

// File: rtl/rtc_freeze_gate.sv
module rtc_freeze_gate #(
  parameter int WINDOW_CYCLES = 1000,
  parameter int PEND_W        = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sec_tick,
  input  logic arm,
  input  logic leave,
  output logic cnt_tick
);
  localparam int WIN_W = $clog2(WINDOW_CYCLES + 1);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic              frozen;
  logic [WIN_W-1:0]  win_cnt;
  logic [PEND_W-1:0] pend;
  logic              timeout;

  assign timeout  = frozen && (win_cnt == WIN_W'(WINDOW_CYCLES - 1));
  assign cnt_tick = run && !frozen && (sec_tick || pend != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen  <= 1'b0;
      win_cnt <= '0;
    end else if (arm) begin
      frozen  <= 1'b1;
      win_cnt <= '0;
    end else if (leave || timeout) begin
      frozen  <= 1'b0;
      win_cnt <= '0;
    end else if (frozen) begin
      win_cnt <= win_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pend <= '0;
    else if (!run)                  pend <= '0;
    else if (frozen) begin
      if (sec_tick && pend != PEND_MAX) pend <= pend + 1'b1;
    end else if (!sec_tick && pend != '0) pend <= pend - 1'b1;
  end

  p_hold_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && run) |=> pend >= $past(pend));
  p_hold_counts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && run && sec_tick) |=> pend != '0);
  p_replay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && run && pend != '0) |-> cnt_tick);
  p_stop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pend == '0);
endmodule

// File: rtl/rtc_clkout_sel.sv
module rtc_clkout_sel
  import rtc_bus_pkg::*;
(
  input  logic [NUM_TAPS-1:0] taps,
  input  logic [SEL_W-1:0]    sel,
  input  logic                pd,
  output logic                clk_out
);
  logic tap_pick;

  always_comb begin
    tap_pick = 1'b1;
    for (int k = 1; k <= NUM_TAPS; k++)
      if (sel == SEL_W'(k)) tap_pick = taps[k-1];
  end

  assign clk_out = !pd && tap_pick;

  always_comb begin
    if (pd) a_pd_low_r10: assert (!clk_out);
  end
endmodule

// File: rtl/rtc_bus_frontend.sv
module rtc_bus_frontend
  import rtc_bus_pkg::*;
#(
  parameter int WINDOW_CYCLES = 1000,
  parameter int PEND_W        = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  addr_strobe,
  input  logic                  cs_in,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  rd_n,
  input  logic                  wr_n,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata,
  output logic                  rdata_oe,
  input  logic                  pd_n,
  input  logic [NUM_CNT*8-1:0]  cnt_values,
  input  logic                  irq_alarm,
  input  logic                  irq_clk,
  input  logic [NUM_TAPS-1:0]   taps,
  input  logic                  sec_tick,
  output logic                  cnt_tick,
  output logic                  cnt_wr_en,
  output logic                  alm_wr_en,
  output logic [2:0]            wr_sel,
  output logic [7:0]            wr_data,
  output logic [1:0]            freq_sel,
  output logic                  run,
  output logic                  alm_target,
  output logic                  clk_out
);
  ctrl_t       ctrl_q;
  logic        cs_lat, pd_active, rd_live, wr_evt, rd_evt;
  logic        acc_done, is_cnt, is_alm;
  logic [2:0]  slot;
  logic [7:0]  rd_byte;

  rtc_bus_decode u_dec (
    .clk, .rst_n, .addr_strobe, .cs_in, .rd_n, .wr_n, .pd_n,
    .cs_lat, .pd_active, .rd_live, .wr_evt, .rd_evt
  );

  assign acc_done = wr_evt || rd_evt;

  rtc_freeze_gate #(.WINDOW_CYCLES(WINDOW_CYCLES), .PEND_W(PEND_W)) u_frz (
    .clk, .rst_n, .run(ctrl_q.run), .sec_tick,
    .arm(acc_done && addr == ADDR_FRZ),
    .leave(acc_done && addr != ADDR_FRZ),
    .cnt_tick
  );

  rtc_clkout_sel u_co (
    .taps, .sel(ctrl_q.clk_sel), .pd(pd_active), .clk_out
  );

  assign slot   = 3'(addr - ADDR_W'(ADDR_CNT0));
  assign is_cnt = (addr >= ADDR_W'(ADDR_CNT0)) && (slot < 3'(NUM_CNT));
  assign is_alm = (addr >= ADDR_W'(ADDR_CNT0)) && (slot < 3'(NUM_ALM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      cnt_wr_en <= 1'b0;
      alm_wr_en <= 1'b0;
      wr_sel    <= '0;
      wr_data   <= '0;
    end else begin
      cnt_wr_en <= wr_evt && is_cnt && !ctrl_q.alm_tgt;
      alm_wr_en <= wr_evt && is_alm && ctrl_q.alm_tgt;
      if (wr_evt) begin
        wr_sel  <= slot;
        wr_data <= wdata;
        if (addr == ADDR_CTRL) ctrl_q <= ctrl_t'(wdata);
      end
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    if (addr == ADDR_CTRL) rd_byte = {irq_alarm, irq_clk, 6'b0};
    for (int i = 0; i < NUM_CNT; i++)
      if (addr == ADDR_W'(ADDR_CNT0 + i)) rd_byte = cnt_values[i*8 +: 8];
  end

  assign rdata_oe   = rd_live;
  assign rdata      = rd_live ? rd_byte : 8'h00;
  assign freq_sel   = ctrl_q.freq;
  assign run        = ctrl_q.run;
  assign alm_target = ctrl_q.alm_tgt;

  p_pd_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |=> !cnt_wr_en && !alm_wr_en);
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cnt_wr_en, alm_wr_en}));
  p_pd_no_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |-> !rdata_oe);
  p_nosel_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_lat |=> !cnt_wr_en && !alm_wr_en);
endmodule

// File: tb/rtc_bus_frontend_tb_top.sv
module rtc_bus_frontend_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        addr_strobe = 0, cs_in = 0, rd_n = 1, wr_n = 1, pd_n = 1;
  logic [2:0]  addr = 0;
  logic [7:0]  wdata = 0, rdata;
  logic        rdata_oe, cnt_tick, cnt_wr_en, alm_wr_en, clk_out, run, alm_target;
  logic [39:0] cnt_values = 0;
  logic        irq_alarm = 0, irq_clk = 0, sec_tick = 0;
  logic [14:0] taps = 0;
  logic [2:0]  wr_sel;
  logic [7:0]  wr_data;
  logic [1:0]  freq_sel;

  int errors = 0, checks = 0, tick_cnt = 0;
  logic [7:0] ctrl_shadow = 0;
  logic       o_cnt, o_alm;
  logic [2:0] o_sel;
  logic [7:0] o_dat, r_dat;
  logic       r_oe;

  always #2 clk = ~clk;

  rtc_bus_frontend dut_i (
    .clk, .rst_n, .addr_strobe, .cs_in, .addr, .rd_n, .wr_n, .wdata,
    .rdata, .rdata_oe, .pd_n, .cnt_values, .irq_alarm, .irq_clk, .taps,
    .sec_tick, .cnt_tick, .cnt_wr_en, .alm_wr_en, .wr_sel, .wr_data,
    .freq_sel, .run, .alm_target, .clk_out
  );

  always @(negedge clk) if (cnt_tick) tick_cnt++;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic bus_sel(logic c);
    addr_strobe = 1; cs_in = c; step();
    addr_strobe = 0; step();
  endtask

  task automatic bus_write(logic [2:0] a, logic [7:0] d);
    addr = a; wdata = d; rd_n = 1; wr_n = 0; step();
    wr_n = 1; step();
    o_cnt = cnt_wr_en; o_alm = alm_wr_en; o_sel = wr_sel; o_dat = wr_data;
    step();
  endtask

  task automatic bus_read(logic [2:0] a);
    addr = a; rd_n = 0; #1;
    r_dat = rdata; r_oe = rdata_oe;
    step(); rd_n = 1; step(2);
  endtask

  task automatic pulse_tick();
    sec_tick = 1; step(); sec_tick = 0; step();
  endtask

  function automatic logic [7:0] exp_read(logic [2:0] a);
    if (a == 0) return {irq_alarm, irq_clk, 6'b0};
    if (a >= 2 && a <= 6) return cnt_values[(a-2)*8 +: 8];
    return 8'h00;
  endfunction

  function automatic logic exp_clk(logic [3:0] s, logic [14:0] t);
    return (s == 0) ? 1'b1 : t[s-1];
  endfunction

  initial begin
    #(4*200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t0;
    void'($urandom(32'd4711));
    step(4); rst_n = 1; step();
    // R1 reset state
    chk("R1 clk_out", clk_out, 1);
    chk("R1 freq_sel", freq_sel, 0);
    chk("R1 run", run, 0);
    chk("R1 rdata_oe", rdata_oe, 0);
    chk("R1 strobes", {cnt_wr_en, alm_wr_en}, 0);
    t0 = tick_cnt; pulse_tick();
    chk("R7 stopped tick", tick_cnt - t0, 0);

    bus_sel(1);
    bus_write(0, 8'h06); ctrl_shadow = 8'h06;
    chk("R3 freq_sel", freq_sel, 2);
    chk("R3 run", run, 1);
    chk("R3 ctrl no strobe", {o_cnt, o_alm}, 0);

    // R5 random reads
    for (int k = 0; k < 6; k++) begin
      cnt_values = {$urandom, $urandom};
      irq_alarm = $urandom; irq_clk = $urandom;
      for (int a = 0; a < 8; a++) begin
        bus_read(3'(a));
        chk("R5 oe", r_oe, 1);
        chk("R5 data", r_dat, exp_read(3'(a)));
      end
    end

    // R4 random writes
    for (int k = 0; k < 16; k++) begin
      logic tg; logic [2:0] a; logic [7:0] d;
      tg = $urandom; a = 3'($urandom_range(1, 7)); d = $urandom;
      ctrl_shadow[3] = tg;
      bus_write(0, ctrl_shadow);
      chk("R3 target", alm_target, tg);
      bus_write(a, d);
      chk("R4 cnt_wr_en", o_cnt, !tg && a >= 2 && a <= 6);
      chk("R4 alm_wr_en", o_alm, tg && a >= 2 && a <= 4);
      if (o_cnt || o_alm) begin
        chk("R4 wr_sel", o_sel, a - 2);
        chk("R4 wr_data", o_dat, d);
      end
    end
    ctrl_shadow[3] = 0;

    // R6 clock output select
    for (int k = 0; k < 10; k++) begin
      logic [3:0] s;
      s = (k == 0) ? 4'd0 : (k == 1) ? 4'd15 : 4'($urandom);
      taps = 15'($urandom);
      ctrl_shadow[7:4] = s;
      bus_write(0, ctrl_shadow);
      chk("R6 clk_out", clk_out, exp_clk(s, taps));
    end
    ctrl_shadow[7:4] = 0; bus_write(0, ctrl_shadow);

    // R7 run gating
    t0 = tick_cnt; pulse_tick();
    chk("R7 live tick", tick_cnt - t0, 1);
    bus_write(0, ctrl_shadow & 8'hFB);
    t0 = tick_cnt; pulse_tick();
    chk("R7 stopped", tick_cnt - t0, 0);
    bus_write(0, ctrl_shadow);

    // R8 / R9 freeze, replay
    bus_read(1);
    t0 = tick_cnt;
    repeat (3) pulse_tick();
    chk("R8 held", tick_cnt - t0, 0);
    bus_read(2);
    step(6);
    chk("R9 replay", tick_cnt - t0, 3);

    // R8 saturation
    bus_write(1, 8'h00);
    t0 = tick_cnt;
    repeat (20) pulse_tick();
    chk("R8 held sat", tick_cnt - t0, 0);
    bus_read(3);
    step(20);
    chk("R8 saturate", tick_cnt - t0, 15);

    // R9 timeout window
    bus_read(1);
    t0 = tick_cnt;
    step(300); pulse_tick();
    chk("R9 in window", tick_cnt - t0, 0);
    step(720);
    chk("R9 timeout release", tick_cnt - t0, 1);
    pulse_tick();
    chk("R9 live after", tick_cnt - t0, 2);

    // R2 deselected bus
    bus_sel(0);
    bus_write(0, 8'h03);
    chk("R2 ignored write", freq_sel, 2);
    chk("R2 no strobe", {o_cnt, o_alm}, 0);
    bus_read(2);
    chk("R2 no oe", r_oe, 0);
    bus_sel(1);

    // R10 power-down
    pd_n = 0; step(2);
    chk("R10 clk_out low", clk_out, 0);
    bus_write(0, 8'h01);
    chk("R10 write ignored", freq_sel, 2);
    chk("R10 no strobe", {o_cnt, o_alm}, 0);
    bus_write(2, 8'h55);
    chk("R10 cnt ignored", o_cnt, 0);
    bus_read(2);
    chk("R10 no oe", r_oe, 0);
    pd_n = 1; step(2);
    chk("R10 released", clk_out, 1);

    // R11 deferral during write
    addr = 0; wdata = 8'h05; wr_n = 0; step();
    pd_n = 0; step(3);
    chk("R11 deferred", clk_out, 1);
    wr_n = 1; step();
    chk("R11 write done", freq_sel, 1);
    chk("R11 pd after", clk_out, 0);
    pd_n = 1; step(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule